// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block is the front end of a small 64-bit processor whose instructions are 1, 2, 9 or 10 bytes long. It holds the program counter and keeps a byte-addressed instruction store. Every cycle it reads a ten-byte window starting at the program counter and splits the leading bytes into an opcode, a function code, two register specifiers and a 64-bit constant. The constant is stored least significant byte first, and where it starts depends on the opcode. The block also presents the address of the next sequential instruction and an instruction-valid flag.

On each clock edge the block picks the next program counter from three sources: the sequential address, the constant (a taken conditional jump or a call), or a return address that the data side has read from the stack. The execute stage, the register file and the data memory sit outside the block. The block receives their results as a condition flag, the loaded return address and a data-memory error.

The block also keeps a sticky status word. While the status reads "running", the program counter advances. The first halt, bad address or illegal opcode freezes the status and the program counter. The program counter then stays on the instruction that caused the stop. A byte-wide load port fills the instruction store.

Top module: `fetch_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0 and `status` to 1 (running) at the next rising edge.
- R2: Bytes written through the load port appear in the fetch window. Field positions are: opcode = bits 7:4 of the byte at `pc`, function = bits 3:0 of that byte, `reg_a` = bits 7:4 of the byte at `pc`+1, `reg_b` = bits 3:0 of the byte at `pc`+1.
- R3: `const_val` is the eight bytes at `pc`+2..`pc`+9 for opcodes 3, 4 and 5. It is the eight bytes at `pc`+1..`pc`+8 for opcodes 7 and 8. The lowest address is the least significant byte. For every other opcode `const_val` is 0.
- R4: `next_seq` is `pc`+1 for opcodes 1, 9, C and the illegal opcodes D to F. It is `pc`+2 for 2, 6, A and B, `pc`+9 for 7 and 8, and `pc`+10 for 3, 4 and 5. For opcode 0 (halt) it equals `pc`.
- R5: While running, the next `pc` depends on the opcode. For opcode 7 it is `const_val` when `cond_in` is 1 and `next_seq` otherwise. For opcode 8 it is `const_val`. For opcode 9 it is `ret_addr`. For every other opcode it is `next_seq`.
- R6: `instr_ok` is 0 for opcodes D, E and F and 1 for opcodes 0 to C.
- R7: Status codes are 1 running, 2 halted, 3 bad address and 4 illegal instruction. From running, opcode 0 gives 2, `dmem_err` gives 3 and `instr_ok`=0 gives 4, each at the next edge. The `pc` keeps the address of the instruction that caused the change.
- R8: Once `status` is not 1, `status` and `pc` stay constant until reset, whatever the inputs.
- R9: When several conditions coincide, halt beats bad address and bad address beats illegal instruction.
- R10: If an instruction's bytes would extend past the last byte of the store, the status becomes 3. This includes a `pc` beyond the store. A `pc` beyond the store reports 3 and not halt. Addresses never wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one byte into the instruction store |
| load_addr | input | ADDR_W | Store byte address for the load |
| load_byte | input | 8 | Byte to store |
| cond_in | input | 1 | Condition result for the conditional jump |
| ret_addr | input | 64 | Return address read from the stack |
| dmem_err | input | 1 | Data-memory access was out of range |
| pc | output | 64 | Program counter |
| opcode | output | 4 | Opcode nibble |
| func | output | 4 | Function nibble |
| reg_a | output | 4 | First register specifier |
| reg_b | output | 4 | Second register specifier |
| const_val | output | 64 | Reassembled 64-bit constant |
| next_seq | output | 64 | Address of the next sequential instruction |
| instr_ok | output | 1 | Opcode is legal |
| status | output | 3 | Sticky processor status |

## Verification
A wrong length or a wrong target selection puts a wrong `pc` on the port at the next edge. From then on every decoded field diverges, so the bench compares `pc` and all decode outputs against a hand-computed trace on every cycle. A wrong or missed status transition shows at `status` one edge after the triggering instruction. A status that fails to stick shows as a `pc` or `status` change in the cycles that follow. The bench therefore keeps driving conflicting inputs into halted and faulted states for extra cycles. Programs that end at the last bytes of the store and beyond it cover the range checks.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int WIN_BYTES = 10;
  localparam int WORD_W    = 64;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_RRMOV = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;
  localparam logic [3:0] OP_RMMOV = 4'h4;
  localparam logic [3:0] OP_MRMOV = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;
  localparam logic [3:0] OP_MAX   = 4'hC;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd1,
    ST_HALT     = 3'd2,
    ST_BADADDR  = 3'd3,
    ST_BADINSN  = 3'd4
  } status_e;

  // bytes an instruction occupies in the store
  function automatic logic [3:0] fetch_len(input logic [3:0] op);
    case (op)
      OP_IRMOV, OP_RMMOV, OP_MRMOV:     fetch_len = 4'd10;
      OP_JUMP, OP_CALL:                 fetch_len = 4'd9;
      OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: fetch_len = 4'd2;
      default:                          fetch_len = 4'd1;
    endcase
  endfunction

  // sequential advance; halt does not move
  function automatic logic [3:0] seq_step(input logic [3:0] op);
    seq_step = (op == OP_HALT) ? 4'd0 : fetch_len(op);
  endfunction

endpackage

// File: rtl/fetch_store.sv
module fetch_store #(
  parameter int MEM_BYTES = 1024,
  parameter int ADDR_W    = $clog2(MEM_BYTES),
  parameter int WIN       = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [63:0]       base,
  output logic [WIN*8-1:0]  window
);

  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // one read lane per window byte; lanes past the end read zero
  for (genvar k = 0; k < WIN; k++) begin : g_lane
    logic [64:0] lane_addr;
    logic        lane_in;
    always_comb begin
      lane_addr = {1'b0, base} + 65'(k);
      lane_in   = lane_addr < 65'(MEM_BYTES);
      window[8*k +: 8] = lane_in ? mem[lane_addr[ADDR_W-1:0]] : 8'h00;
    end
  end

endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
  import fetch_pkg::*;
#(
  parameter int MEM_BYTES = 1024
) (
  input  logic [63:0]            pc,
  input  logic [WIN_BYTES*8-1:0] window,
  output logic [3:0]             opcode,
  output logic [3:0]             func,
  output logic [3:0]             reg_a,
  output logic [3:0]             reg_b,
  output logic [63:0]            const_val,
  output logic [63:0]            next_seq,
  output logic                   instr_ok,
  output logic                   head_miss,
  output logic                   tail_miss
);

  logic [3:0] len;

  always_comb begin
    opcode = window[7:4];
    func   = window[3:0];
    reg_a  = window[15:12];
    reg_b  = window[11:8];

    case (opcode)
      OP_IRMOV, OP_RMMOV, OP_MRMOV: const_val = window[79:16];
      OP_JUMP, OP_CALL:             const_val = window[71:8];
      default:                      const_val = '0;
    endcase

    len       = fetch_len(opcode);
    next_seq  = pc + 64'(seq_step(opcode));
    instr_ok  = opcode <= OP_MAX;
    head_miss = pc >= 64'(MEM_BYTES);
    tail_miss = ({1'b0, pc} + 65'(len)) > 65'(MEM_BYTES);
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  opcode,
  input  logic [63:0] const_val,
  input  logic [63:0] next_seq,
  input  logic        instr_ok,
  input  logic        head_miss,
  input  logic        tail_miss,
  input  logic        cond_in,
  input  logic [63:0] ret_addr,
  input  logic        dmem_err,
  output logic [63:0] pc,
  output status_e     status
);

  status_e     code;
  logic [63:0] target;

  always_comb begin
    if (head_miss)                   code = ST_BADADDR;
    else if (opcode == OP_HALT)      code = ST_HALT;
    else if (tail_miss || dmem_err)  code = ST_BADADDR;
    else if (!instr_ok)              code = ST_BADINSN;
    else                             code = ST_RUN;

    case (opcode)
      OP_JUMP: target = cond_in ? const_val : next_seq;
      OP_CALL: target = const_val;
      OP_RET:  target = ret_addr;
      default: target = next_seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      status <= ST_RUN;
    end else if (status == ST_RUN) begin
      status <= code;
      if (code == ST_RUN) pc <= target;
    end
  end

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [7:0]        load_byte,
  input  logic              cond_in,
  input  logic [63:0]       ret_addr,
  input  logic              dmem_err,
  output logic [63:0]       pc,
  output logic [3:0]        opcode,
  output logic [3:0]        func,
  output logic [3:0]        reg_a,
  output logic [3:0]        reg_b,
  output logic [63:0]       const_val,
  output logic [63:0]       next_seq,
  output logic              instr_ok,
  output logic [2:0]        status
);

  logic [WIN_BYTES*8-1:0] window;
  logic                   head_miss;
  logic                   tail_miss;
  status_e                st_q;

  fetch_store #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W), .WIN(WIN_BYTES)) u_store (
    .clk    (clk),
    .wr_en  (load_en),
    .wr_addr(load_addr),
    .wr_data(load_byte),
    .base   (pc),
    .window (window)
  );

  fetch_decode #(.MEM_BYTES(MEM_BYTES)) u_decode (
    .pc       (pc),
    .window   (window),
    .opcode   (opcode),
    .func     (func),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .const_val(const_val),
    .next_seq (next_seq),
    .instr_ok (instr_ok),
    .head_miss(head_miss),
    .tail_miss(tail_miss)
  );

  fetch_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .const_val(const_val),
    .next_seq (next_seq),
    .instr_ok (instr_ok),
    .head_miss(head_miss),
    .tail_miss(tail_miss),
    .cond_in  (cond_in),
    .ret_addr (ret_addr),
    .dmem_err (dmem_err),
    .pc       (pc),
    .status   (st_q)
  );

  assign status = st_q;

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int MEM_BYTES = 1024
) (
  input logic        clk,
  input logic        rst,
  input logic [63:0] pc,
  input logic [2:0]  status,
  input logic [3:0]  opcode,
  input logic [63:0] const_val,
  input logic [63:0] ret_addr,
  input logic        instr_ok,
  input logic        dmem_err
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc == 64'd0 && status == 3'd1));

  p_status_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (status != 3'd0 && status <= 3'd4));

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (status != 3'd1) |=> ($stable(status) && $stable(pc)));

  p_call_target_r5: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd1 && opcode == 4'h8) |=> (status != 3'd1 || pc == $past(const_val)));

  p_ret_target_r5: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd1 && opcode == 4'h9) |=> (status != 3'd1 || pc == $past(ret_addr)));

  p_halt_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd1 && opcode == 4'h0 && pc < 64'(MEM_BYTES)) |=> (status == 3'd2 && $stable(pc)));

  p_illegal_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd1 && !instr_ok && !dmem_err && pc < 64'(MEM_BYTES)) |=> (status == 3'd4));

endmodule

bind fetch_unit fetch_unit_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc),
  .status   (status),
  .opcode   (opcode),
  .const_val(const_val),
  .ret_addr (ret_addr),
  .instr_ok (instr_ok),
  .dmem_err (dmem_err)
);

// File: tb/tb_fetch_unit.sv
module tb_fetch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 1024;
  localparam int ADDR_W     = $clog2(MEM_BYTES);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_en = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [7:0]        load_byte = '0;
  logic              cond_in = 1'b0;
  logic [63:0]       ret_addr = '0;
  logic              dmem_err = 1'b0;
  logic [63:0]       pc;
  logic [3:0]        opcode, func, reg_a, reg_b;
  logic [63:0]       const_val, next_seq;
  logic              instr_ok;
  logic [2:0]        status;

  fetch_unit #(.MEM_BYTES(MEM_BYTES)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_byte(load_byte), .cond_in(cond_in), .ret_addr(ret_addr),
    .dmem_err(dmem_err), .pc(pc), .opcode(opcode), .func(func),
    .reg_a(reg_a), .reg_b(reg_b), .const_val(const_val),
    .next_seq(next_seq), .instr_ok(instr_ok), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [63:0] pc;
    logic [2:0]  st;
    logic        dec;
    logic [3:0]  op, fn, ra, rb;
    logic [63:0] c, ns;
    logic        ok;
    logic        cond;
    logic [63:0] ret;
    logic        derr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nfail = 0;
  logic run = 1'b0;

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // driver side: queue a fully decoded cycle
  task automatic step(logic [63:0] p, logic [3:0] op, logic [3:0] fn, logic [3:0] ra,
                      logic [3:0] rb, logic [63:0] c, logic [63:0] ns, logic ok,
                      logic cond, logic [63:0] ret, logic derr, string tag);
    exp_t e;
    e.pc = p; e.st = 3'd1; e.dec = 1'b1; e.op = op; e.fn = fn; e.ra = ra; e.rb = rb;
    e.c = c; e.ns = ns; e.ok = ok; e.cond = cond; e.ret = ret; e.derr = derr; e.tag = tag;
    q.push_back(e);
  endtask

  // driver side: queue a cycle where only pc and status are checked
  task automatic hold(logic [63:0] p, logic [2:0] st, logic cond, logic derr, string tag);
    exp_t e;
    e.pc = p; e.st = st; e.dec = 1'b0; e.op = '0; e.fn = '0; e.ra = '0; e.rb = '0;
    e.c = '0; e.ns = '0; e.ok = 1'b0; e.cond = cond; e.ret = 64'hDEAD; e.derr = derr;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one expected item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (run && q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      cond_in  = e.cond;
      ret_addr = e.ret;
      dmem_err = e.derr;
      cmp({e.tag, " pc"}, pc, e.pc);
      cmp({e.tag, " status"}, 64'(status), 64'(e.st));
      if (e.dec) begin
        cmp({e.tag, " R2 opcode"}, 64'(opcode), 64'(e.op));
        cmp({e.tag, " R2 func"}, 64'(func), 64'(e.fn));
        cmp({e.tag, " R2 reg_a"}, 64'(reg_a), 64'(e.ra));
        cmp({e.tag, " R2 reg_b"}, 64'(reg_b), 64'(e.rb));
        cmp({e.tag, " R3 const"}, const_val, e.c);
        cmp({e.tag, " R4 next_seq"}, next_seq, e.ns);
        cmp({e.tag, " R6 instr_ok"}, 64'(instr_ok), 64'(e.ok));
      end
    end
  end

  task automatic wb(int a, logic [7:0] b);
    load_en = 1'b1; load_addr = ADDR_W'(a); load_byte = b;
    @(posedge clk); #1;
    load_en = 1'b0;
  endtask

  task automatic w64(int a, logic [63:0] v);
    for (int i = 0; i < 8; i++) wb(a + i, v[8*i +: 8]);
  endtask

  task automatic clear_head();
    for (int i = 0; i < 12; i++) wb(i, 8'h00);
  endtask

  task automatic check_reset();
    @(posedge clk);
    @(negedge clk);
    cmp("R1 reset pc", pc, 64'd0);
    cmp("R1 reset status", 64'(status), 64'd1);
  endtask

  task automatic run_prog();
    @(posedge clk); #1;
    rst = 1'b0; run = 1'b1;
    while (q.size() != 0) @(posedge clk);
    #1;
    run = 1'b0; rst = 1'b1;
    cond_in = 1'b0; dmem_err = 1'b0; ret_addr = '0;
    check_reset();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) wb(i, 8'h00);
    check_reset();

    // program A: every length, constant placement and PC source
    wb(0, 8'h30); wb(1, 8'hF3); w64(2, 64'h1122334455667788);
    wb(10, 8'h60); wb(11, 8'h12);
    wb(12, 8'h10);
    wb(13, 8'h74); w64(14, 64'd32);
    wb(22, 8'h70); w64(23, 64'd40);
    wb(40, 8'h80); w64(41, 64'd70);
    wb(49, 8'h20); wb(50, 8'h45);
    wb(51, 8'h50); wb(52, 8'h67); w64(53, 64'hFFEEDDCCBBAA9988);
    wb(61, 8'hB0); wb(62, 8'h3F);
    wb(63, 8'h00);
    wb(70, 8'h90);
    step(0,  4'h3, 4'h0, 4'hF, 4'h3, 64'h1122334455667788, 10, 1, 0, 0, 0, "R3 R4 imm move");
    step(10, 4'h6, 4'h0, 4'h1, 4'h2, 0, 12, 1, 0, 0, 0, "R4 alu");
    step(12, 4'h1, 4'h0, 4'h7, 4'h4, 0, 13, 1, 0, 0, 0, "R4 nop");
    step(13, 4'h7, 4'h4, 4'h2, 4'h0, 32, 22, 1, 0, 0, 0, "R5 jump not taken");
    step(22, 4'h7, 4'h0, 4'h2, 4'h8, 40, 31, 1, 1, 0, 0, "R5 jump taken");
    step(40, 4'h8, 4'h0, 4'h4, 4'h6, 70, 49, 1, 0, 0, 0, "R5 call");
    step(70, 4'h9, 4'h0, 4'h0, 4'h0, 0, 71, 1, 0, 49, 0, "R5 ret");
    step(49, 4'h2, 4'h0, 4'h4, 4'h5, 0, 51, 1, 0, 0, 0, "R5 R4 reg move");
    step(51, 4'h5, 4'h0, 4'h6, 4'h7, 64'hFFEEDDCCBBAA9988, 61, 1, 0, 0, 0, "R3 load move");
    step(61, 4'hB, 4'h0, 4'h3, 4'hF, 0, 63, 1, 0, 0, 0, "R4 pop");
    step(63, 4'h0, 4'h0, 4'h0, 4'h0, 0, 63, 1, 0, 0, 0, "R4 halt");
    hold(63, 3'd2, 0, 0, "R7 halted");
    hold(63, 3'd2, 1, 1, "R8 halt sticky");
    run_prog();

    // program B: data-memory error
    clear_head();
    wb(0, 8'h10);
    step(0, 4'h1, 4'h0, 4'h0, 4'h0, 0, 1, 1, 0, 0, 1, "R7 data error");
    hold(0, 3'd3, 0, 0, "R7 bad address");
    hold(0, 3'd3, 1, 0, "R8 bad address sticky");
    run_prog();

    // program C: opcode C legal, D illegal
    clear_head();
    wb(0, 8'hC0); wb(1, 8'hD5);
    step(0, 4'hC, 4'h0, 4'hD, 4'h5, 0, 1, 1, 0, 0, 0, "R6 opcode C legal");
    step(1, 4'hD, 4'h5, 4'h0, 4'h0, 0, 2, 0, 0, 0, 0, "R6 opcode D illegal");
    hold(1, 3'd4, 0, 0, "R7 illegal");
    hold(1, 3'd4, 0, 1, "R8 illegal sticky");
    run_prog();

    // program D: bad address beats illegal
    clear_head();
    wb(0, 8'hE0);
    step(0, 4'hE, 4'h0, 4'h0, 4'h0, 0, 1, 0, 0, 0, 1, "R9 illegal with error");
    hold(0, 3'd3, 0, 0, "R9 address beats illegal");
    run_prog();

    // program E: halt beats bad address
    clear_head();
    step(0, 4'h0, 4'h0, 4'h0, 4'h0, 0, 0, 1, 0, 0, 1, "R9 halt with error");
    hold(0, 3'd2, 0, 0, "R9 halt beats address");
    run_prog();

    // program F: ten-byte instruction running off the end
    clear_head();
    wb(0, 8'h70); w64(1, 64'd1019);
    wb(1019, 8'h30);
    step(0, 4'h7, 4'h0, 4'hF, 4'hB, 1019, 9, 1, 1, 0, 0, "R5 jump to tail");
    step(1019, 4'h3, 4'h0, 4'h0, 4'h0, 0, 1029, 1, 0, 0, 0, "R10 tail fetch");
    hold(1019, 3'd3, 0, 0, "R10 tail overrun");
    run_prog();

    // program G: pc beyond the store
    clear_head();
    wb(0, 8'h70); w64(1, 64'd2000);
    step(0, 4'h7, 4'h0, 4'hD, 4'h0, 2000, 9, 1, 1, 0, 0, "R5 jump outside");
    step(2000, 4'h0, 4'h0, 4'h0, 4'h0, 0, 2000, 1, 0, 0, 0, "R10 outside reads zero");
    hold(2000, 3'd3, 0, 0, "R10 outside is bad address");
    hold(2000, 3'd3, 1, 0, "R8 outside sticky");
    run_prog();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule